// File: doc/BRIEF.md
# Reference-Counted Chunk Store Controller

This controller keeps a pool of fixed-size chunks for a heap whose objects never change after they are written. Every chunk carries a 1024-bit payload and an 8-bit type/format tag. A requester names a chunk with a 64-bit identifier. The identifier has two parts: the low 6 bits select one of 64 slots, and the upper 58 bits hold a generation number. The generation of a slot advances every time the slot is reclaimed, so an identifier kept after its chunk died no longer matches and is recognised as stale.

There are five operations on a single request/response channel:

- take a fresh identifier;
- commit a whole chunk;
- read a whole chunk back;
- raise a reference count;
- lower a reference count.

When a count drops from one to zero, the slot is reclaimed in that same operation and can be handed out again. Once a chunk is committed, its contents can never be rewritten. A chunk that carries pointer fields may only be committed while no more than one reference to it exists, which keeps the reference graph acyclic. Each response reports whether the requester could have updated the chunk in place (count one, not yet committed). When that flag is clear, the requester must make a copy instead.

Every request produces exactly one response on the next clock cycle, carrying a 3-bit status code. A request that fails changes no state.

Top module: `cs_chunk_store`

## Requirements
- R1: An allocate request (op code 1) returns status OK (0) and the identifier {generation, index}. The index is the lowest free slot, and the generation is that slot's current value, starting at 0 after reset. The new chunk starts with count 1, not committed, and the in-place flag set.
- R2: With all slots in use, an allocate request returns NO_SPACE (2) and changes no state. The slot that frees up next is the one the following allocation receives.
- R3: A store (op 2) to a chunk that is already committed returns IMMUTABLE (3), and the stored payload and tag remain those of the first store.
- R4: A read (op 3) of a committed chunk returns OK with the full 1024-bit payload and the 8-bit tag in a single response. A read of a chunk that was allocated but never committed returns NOT_STORED (5).
- R5: A store with the pointer flag set, to a chunk whose count is greater than one, returns POINTER (4) and leaves the chunk uncommitted. With the pointer flag clear, the same store succeeds.
- R6: The in-place flag is set in a response exactly when the status is OK and, before the operation, the chunk had count 1 and was not committed. On allocate it is always set.
- R7: An increment (op 4) or decrement (op 5) returns OK. A decrement from count 1 reclaims the slot, after which the old identifier is stale. The next allocation of that slot carries generation + 1.
- R8: A store, read, increment or decrement whose identifier has no live slot, or whose generation does not match, returns BAD_ID (1) and changes no state.
- R9: An increment of a chunk whose count is at its maximum (255) returns OVERFLOW (6) and leaves the count unchanged.
- R10: Each valid request gets exactly one response, rsp_valid, on the following cycle, and no response appears without a request. Op codes 0, 6 and 7 return BAD_OP (7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation: 1 allocate, 2 store, 3 read, 4 increment, 5 decrement |
| req_id | input | 64 | Target identifier {generation[57:0], index[5:0]} |
| req_data | input | 1024 | Payload for a store |
| req_aux | input | 8 | Type/format tag for a store |
| req_ptr | input | 1 | The stored payload contains pointer fields |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 3 | Status code (see requirements) |
| rsp_id | output | 64 | Allocated identifier, or the request identifier echoed |
| rsp_inplace | output | 1 | An in-place update would have been allowed |
| rsp_data | output | 1024 | Payload returned by a read |
| rsp_aux | output | 8 | Tag returned by a read |

## Verification
The bench goes after the edges of the slot life cycle: a second store to a committed chunk, a pointer store made while two references exist, a read before commit, and a decrement that takes a count to zero. Each is followed by a read or an allocation that shows whether the state really moved. A design that forgot to advance the generation would accept the stale identifier on a later read. A design that let a rejected store through would return the second payload. The bench fills every slot and then asks once more, which catches a pool that overruns or hands out a live slot. It also drives one count to 255 and increments again, which catches a counter that wraps to zero and so reclaims a chunk that still has references.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int CS_CHUNKS = 64;
    localparam int CS_ID_W   = 64;
    localparam int CS_DATA_W = 1024;
    localparam int CS_AUX_W  = 8;
    localparam int CS_CNT_W  = 8;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ALLOC = 3'd1,
        OP_STORE = 3'd2,
        OP_READ  = 3'd3,
        OP_INC   = 3'd4,
        OP_DEC   = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_OK         = 3'd0,
        ST_BAD_ID     = 3'd1,
        ST_NO_SPACE   = 3'd2,
        ST_IMMUTABLE  = 3'd3,
        ST_POINTER    = 3'd4,
        ST_NOT_STORED = 3'd5,
        ST_OVERFLOW   = 3'd6,
        ST_BAD_OP     = 3'd7
    } status_e;

    typedef struct packed {
        logic alloc;
        logic commit;
        logic inc;
        logic dec;
        logic rd;
    } action_t;

    localparam action_t ACT_NONE = '{alloc: 1'b0, commit: 1'b0, inc: 1'b0, dec: 1'b0, rd: 1'b0};

endpackage

// File: rtl/cs_free_pool.sv
module cs_free_pool #(
    parameter int N_CHUNKS = 64,
    localparam int IDX_W = $clog2(N_CHUNKS)
) (
    input  logic [N_CHUNKS-1:0] live_vec,
    output logic                have_free,
    output logic [IDX_W-1:0]    free_idx
);

    always_comb begin
        free_idx = '0;
        for (int i = N_CHUNKS - 1; i >= 0; i--) begin
            if (!live_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign have_free = ~&live_vec;

endmodule

// File: rtl/cs_meta_table.sv
module cs_meta_table #(
    parameter int N_CHUNKS = 64,
    parameter int GEN_W    = 58,
    parameter int CNT_W    = 8,
    localparam int IDX_W = $clog2(N_CHUNKS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    look_idx,
    input  logic                alloc_en,
    input  logic [IDX_W-1:0]    alloc_idx,
    input  logic                commit_en,
    input  logic                inc_en,
    input  logic                dec_en,
    output logic [N_CHUNKS-1:0] live_vec,
    output logic                look_live,
    output logic                look_stored,
    output logic [CNT_W-1:0]    look_cnt,
    output logic [GEN_W-1:0]    look_gen,
    output logic [GEN_W-1:0]    alloc_gen
);

    logic [N_CHUNKS-1:0] live_q;
    logic [N_CHUNKS-1:0] stored_q;
    logic [CNT_W-1:0]    cnt_q [N_CHUNKS];
    logic [GEN_W-1:0]    gen_q [N_CHUNKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q   <= '0;
            stored_q <= '0;
            for (int i = 0; i < N_CHUNKS; i++) begin
                cnt_q[i] <= '0;
                gen_q[i] <= '0;
            end
        end else begin
            if (alloc_en) begin
                live_q[alloc_idx]   <= 1'b1;
                stored_q[alloc_idx] <= 1'b0;
                cnt_q[alloc_idx]    <= CNT_W'(1);
            end
            if (commit_en) stored_q[look_idx] <= 1'b1;
            if (inc_en) cnt_q[look_idx] <= cnt_q[look_idx] + CNT_W'(1);
            if (dec_en) begin
                if (cnt_q[look_idx] == CNT_W'(1)) begin
                    live_q[look_idx]   <= 1'b0;
                    stored_q[look_idx] <= 1'b0;
                    cnt_q[look_idx]    <= '0;
                    gen_q[look_idx]    <= gen_q[look_idx] + GEN_W'(1);
                end else begin
                    cnt_q[look_idx] <= cnt_q[look_idx] - CNT_W'(1);
                end
            end
        end
    end

    assign live_vec    = live_q;
    assign look_live   = live_q[look_idx];
    assign look_stored = stored_q[look_idx];
    assign look_cnt    = cnt_q[look_idx];
    assign look_gen    = gen_q[look_idx];
    assign alloc_gen   = gen_q[alloc_idx];

endmodule

// File: rtl/cs_data_array.sv
module cs_data_array #(
    parameter int N_CHUNKS = 64,
    parameter int DATA_W   = 1024,
    parameter int AUX_W    = 8,
    localparam int IDX_W = $clog2(N_CHUNKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AUX_W-1:0]  wr_aux,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [AUX_W-1:0]  rd_aux
);

    typedef struct packed {
        logic [AUX_W-1:0]  aux;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t mem [N_CHUNKS];
    entry_t out_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= '{aux: wr_aux, data: wr_data};
    end

    always_ff @(posedge clk) begin
        if (rst || !rd_en) out_q <= '0;
        else               out_q <= mem[rd_idx];
    end

    assign rd_data = out_q.data;
    assign rd_aux  = out_q.aux;

endmodule

// File: rtl/cs_chunk_store.sv
module cs_chunk_store
    import cs_pkg::*;
#(
    parameter int N_CHUNKS = CS_CHUNKS,
    parameter int ID_W     = CS_ID_W,
    parameter int DATA_W   = CS_DATA_W,
    parameter int AUX_W    = CS_AUX_W,
    parameter int CNT_W    = CS_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ID_W-1:0]   req_id,
    input  logic [DATA_W-1:0] req_data,
    input  logic [AUX_W-1:0]  req_aux,
    input  logic              req_ptr,
    output logic              rsp_valid,
    output logic [2:0]        rsp_status,
    output logic [ID_W-1:0]   rsp_id,
    output logic              rsp_inplace,
    output logic [DATA_W-1:0] rsp_data,
    output logic [AUX_W-1:0]  rsp_aux
);

    localparam int IDX_W = $clog2(N_CHUNKS);
    localparam int GEN_W = ID_W - IDX_W;

    logic [IDX_W-1:0]    look_idx;
    logic [GEN_W-1:0]    req_gen;
    logic [N_CHUNKS-1:0] live_vec;
    logic                have_free;
    logic [IDX_W-1:0]    free_idx;
    logic                look_live;
    logic                look_stored;
    logic [CNT_W-1:0]    look_cnt;
    logic [GEN_W-1:0]    look_gen;
    logic [GEN_W-1:0]    alloc_gen;
    logic                id_ok;
    logic                fresh_now;
    status_e             st;
    action_t             act;
    logic [ID_W-1:0]     out_id;
    logic                out_ip;

    assign look_idx  = req_id[IDX_W-1:0];
    assign req_gen   = req_id[ID_W-1:IDX_W];
    assign id_ok     = look_live && (look_gen == req_gen);
    assign fresh_now = (look_cnt == CNT_W'(1)) && !look_stored;

    cs_free_pool #(.N_CHUNKS(N_CHUNKS)) u_pool (
        .live_vec  (live_vec),
        .have_free (have_free),
        .free_idx  (free_idx)
    );

    cs_meta_table #(.N_CHUNKS(N_CHUNKS), .GEN_W(GEN_W), .CNT_W(CNT_W)) u_meta (
        .clk         (clk),
        .rst         (rst),
        .look_idx    (look_idx),
        .alloc_en    (act.alloc),
        .alloc_idx   (free_idx),
        .commit_en   (act.commit),
        .inc_en      (act.inc),
        .dec_en      (act.dec),
        .live_vec    (live_vec),
        .look_live   (look_live),
        .look_stored (look_stored),
        .look_cnt    (look_cnt),
        .look_gen    (look_gen),
        .alloc_gen   (alloc_gen)
    );

    cs_data_array #(.N_CHUNKS(N_CHUNKS), .DATA_W(DATA_W), .AUX_W(AUX_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (act.commit),
        .wr_idx  (look_idx),
        .wr_data (req_data),
        .wr_aux  (req_aux),
        .rd_en   (act.rd),
        .rd_idx  (look_idx),
        .rd_data (rsp_data),
        .rd_aux  (rsp_aux)
    );

    // Decode: every check of the request against the slot state happens here,
    // and at most one action is raised so the table sees a single update.
    always_comb begin
        st     = ST_OK;
        act    = ACT_NONE;
        out_id = req_id;
        out_ip = 1'b0;
        if (req_valid) begin
            case (req_op)
                OP_ALLOC: begin
                    if (have_free) begin
                        act.alloc = 1'b1;
                        out_id    = {alloc_gen, free_idx};
                        out_ip    = 1'b1;
                    end else begin
                        st = ST_NO_SPACE;
                    end
                end
                OP_STORE: begin
                    if (!id_ok)                                 st = ST_BAD_ID;
                    else if (look_stored)                       st = ST_IMMUTABLE;
                    else if (req_ptr && look_cnt > CNT_W'(1))   st = ST_POINTER;
                    else begin
                        act.commit = 1'b1;
                        out_ip     = fresh_now;
                    end
                end
                OP_READ: begin
                    if (!id_ok)            st = ST_BAD_ID;
                    else if (!look_stored) st = ST_NOT_STORED;
                    else                   act.rd = 1'b1;
                end
                OP_INC: begin
                    if (!id_ok)              st = ST_BAD_ID;
                    else if (&look_cnt)      st = ST_OVERFLOW;
                    else begin
                        act.inc = 1'b1;
                        out_ip  = fresh_now;
                    end
                end
                OP_DEC: begin
                    if (!id_ok) st = ST_BAD_ID;
                    else begin
                        act.dec = 1'b1;
                        out_ip  = fresh_now;
                    end
                end
                default: st = ST_BAD_OP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_status  <= ST_OK;
            rsp_id      <= '0;
            rsp_inplace <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_status  <= st;
            rsp_id      <= out_id;
            rsp_inplace <= out_ip;
        end
    end

endmodule

// File: rtl/cs_chunk_store_chk.sv
module cs_chunk_store_chk
    import cs_pkg::*;
#(
    parameter int N_CHUNKS = 64,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [2:0]          req_op,
    input logic                rsp_valid,
    input logic [2:0]          rsp_status,
    input logic                rsp_inplace,
    input logic [N_CHUNKS-1:0] live_vec,
    input logic                id_ok,
    input logic                look_stored,
    input logic [CNT_W-1:0]    look_cnt
);

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_no_space_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_ALLOC && &live_vec) |=> rsp_status == ST_NO_SPACE);

    assert_write_once_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_STORE && id_ok && look_stored) |=> rsp_status == ST_IMMUTABLE);

    assert_inplace_only_ok_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_inplace) |-> rsp_status == ST_OK);

    assert_count_saturates_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_INC && id_ok && &look_cnt) |=> rsp_status == ST_OVERFLOW);

    assert_pool_step_R7: assert property (@(posedge clk) disable iff (rst)
        ($countones(live_vec) <= $past($countones(live_vec)) + 1) &&
        ($countones(live_vec) + 1 >= $past($countones(live_vec))));

endmodule

bind cs_chunk_store cs_chunk_store_chk #(.N_CHUNKS(N_CHUNKS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .rsp_inplace (rsp_inplace),
    .live_vec    (live_vec),
    .id_ok       (id_ok),
    .look_stored (look_stored),
    .look_cnt    (look_cnt)
);

// File: tb/cs_chunk_store_test.sv
module cs_chunk_store_test;

    localparam int N    = 64;
    localparam int DW   = 1024;
    localparam int MAXC = 255;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [63:0]   req_id = '0;
    logic [DW-1:0] req_data = '0;
    logic [7:0]    req_aux = '0;
    logic          req_ptr = 1'b0;
    logic          rsp_valid;
    logic [2:0]    rsp_status;
    logic [63:0]   rsp_id;
    logic          rsp_inplace;
    logic [DW-1:0] rsp_data;
    logic [7:0]    rsp_aux;

    cs_chunk_store uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_id(req_id),
        .req_data(req_data), .req_aux(req_aux), .req_ptr(req_ptr),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_id(rsp_id),
        .rsp_inplace(rsp_inplace), .rsp_data(rsp_data), .rsp_aux(rsp_aux)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [2:0]    st;
        logic [63:0]   id;
        logic          ip;
        logic          chk_data;
        logic [DW-1:0] data;
        logic [7:0]    aux;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;

    // Reference state, kept from the requirements
    logic          m_live   [N];
    logic          m_stored [N];
    int            m_cnt    [N];
    logic [57:0]   m_gen    [N];
    logic [DW-1:0] m_data   [N];
    logic [7:0]    m_aux    [N];

    function automatic logic [DW-1:0] pat(int seed);
        logic [DW-1:0] v;
        for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(i);
        return v;
    endfunction

    task automatic send(input logic [2:0] op, input logic [63:0] id, input logic [DW-1:0] d,
                        input logic [7:0] a, input logic p, input string tag);
        exp_t e;
        int ix;
        logic ok;
        logic fresh;
        ix = int'(id[5:0]);
        ok = m_live[ix] && (m_gen[ix] == id[63:6]);
        fresh = (m_cnt[ix] == 1) && !m_stored[ix];
        e.st = 3'd0; e.id = id; e.ip = 1'b0; e.chk_data = 1'b0; e.data = '0; e.aux = '0; e.tag = tag;
        case (op)
            3'd1: begin
                int f;
                f = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_live[i]) f = i;
                if (f < 0) e.st = 3'd2;
                else begin
                    e.id = {m_gen[f], 6'(f)}; e.ip = 1'b1;
                    m_live[f] = 1'b1; m_stored[f] = 1'b0; m_cnt[f] = 1;
                end
            end
            3'd2: begin
                if (!ok) e.st = 3'd1;
                else if (m_stored[ix]) e.st = 3'd3;
                else if (p && m_cnt[ix] > 1) e.st = 3'd4;
                else begin
                    e.ip = fresh; m_stored[ix] = 1'b1; m_data[ix] = d; m_aux[ix] = a;
                end
            end
            3'd3: begin
                if (!ok) e.st = 3'd1;
                else if (!m_stored[ix]) e.st = 3'd5;
                else begin
                    e.chk_data = 1'b1; e.data = m_data[ix]; e.aux = m_aux[ix];
                end
            end
            3'd4: begin
                if (!ok) e.st = 3'd1;
                else if (m_cnt[ix] == MAXC) e.st = 3'd6;
                else begin e.ip = fresh; m_cnt[ix]++; end
            end
            3'd5: begin
                if (!ok) e.st = 3'd1;
                else begin
                    e.ip = fresh;
                    m_cnt[ix]--;
                    if (m_cnt[ix] == 0) begin
                        m_live[ix] = 1'b0; m_stored[ix] = 1'b0; m_gen[ix] = m_gen[ix] + 58'd1;
                    end
                end
            end
            default: e.st = 3'd7;
        endcase
        @(posedge clk);
        #1;
        req_valid = 1'b1; req_op = op; req_id = id; req_data = d; req_aux = a; req_ptr = p;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            req_valid = 1'b0;
        end
    endtask

    function automatic logic [63:0] mk(input int g, input int ix);
        return {58'(g), 6'(ix)};
    endfunction

    // Monitor: compare each response against the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected response: actual status %0d expected none", rsp_status);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_status !== e.st || rsp_id !== e.id || rsp_inplace !== e.ip) begin
                    errors++;
                    $display("FAIL %s: actual st=%0d id=%h ip=%0d expected st=%0d id=%h ip=%0d",
                             e.tag, rsp_status, rsp_id, rsp_inplace, e.st, e.id, e.ip);
                end else if (e.chk_data && (rsp_data !== e.data || rsp_aux !== e.aux)) begin
                    errors++;
                    $display("FAIL %s: actual aux=%h data=%h expected aux=%h data=%h",
                             e.tag, rsp_aux, rsp_data, e.aux, e.data);
                end
            end
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_live[i] = 1'b0; m_stored[i] = 1'b0; m_cnt[i] = 0; m_gen[i] = '0;
            m_data[i] = '0; m_aux[i] = '0;
        end
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: actual rsp_valid %0d expected 0", rsp_valid);
        end

        send(3'd1, '0, '0, '0, 1'b0, "R1 first alloc");
        send(3'd1, '0, '0, '0, 1'b0, "R1 second alloc");
        send(3'd3, mk(0, 0), '0, '0, 1'b0, "R4 read before commit");
        send(3'd2, mk(0, 0), pat(1), 8'h5A, 1'b0, "R6 fresh store");
        send(3'd3, mk(0, 0), '0, '0, 1'b0, "R4 read committed");
        send(3'd2, mk(0, 0), pat(2), 8'hC3, 1'b0, "R3 second store");
        send(3'd3, mk(0, 0), '0, '0, 1'b0, "R3 payload kept");
        send(3'd4, mk(0, 1), '0, '0, 1'b0, "R7 increment");
        send(3'd2, mk(0, 1), pat(3), 8'h11, 1'b1, "R5 pointer store shared");
        send(3'd3, mk(0, 1), '0, '0, 1'b0, "R5 still uncommitted");
        send(3'd2, mk(0, 1), pat(4), 8'h22, 1'b0, "R5 plain store shared");
        send(3'd3, mk(0, 1), '0, '0, 1'b0, "R4 read second chunk");
        send(3'd5, mk(0, 1), '0, '0, 1'b0, "R7 decrement to one");
        send(3'd5, mk(0, 1), '0, '0, 1'b0, "R7 decrement to zero");
        send(3'd3, mk(0, 1), '0, '0, 1'b0, "R7 stale read");
        send(3'd5, mk(0, 1), '0, '0, 1'b0, "R8 stale decrement");
        send(3'd1, '0, '0, '0, 1'b0, "R7 reuse bumps generation");
        send(3'd4, mk(0, 5), '0, '0, 1'b0, "R8 unallocated increment");
        send(3'd2, mk(3, 0), pat(5), 8'h33, 1'b0, "R8 wrong generation store");
        send(3'd3, mk(0, 0), '0, '0, 1'b0, "R8 no change after bad id");
        send(3'd0, '0, '0, '0, 1'b0, "R10 op zero");
        send(3'd6, '0, '0, '0, 1'b0, "R10 op six");
        send(3'd7, '0, '0, '0, 1'b0, "R10 op seven");
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 idle drain: actual %0d pending expected 0", exp_q.size());
        end

        for (int i = 0; i < 62; i++) send(3'd1, '0, '0, '0, 1'b0, "R1 fill pool");
        send(3'd1, '0, '0, '0, 1'b0, "R2 pool exhausted");
        send(3'd1, '0, '0, '0, 1'b0, "R2 pool still exhausted");
        send(3'd5, mk(1, 1), '0, '0, 1'b0, "R7 free slot one");
        send(3'd1, '0, '0, '0, 1'b0, "R2 freed slot reused");

        for (int i = 0; i < MAXC - 1; i++) send(3'd4, mk(0, 5), '0, '0, 1'b0, "R9 count up");
        send(3'd4, mk(0, 5), '0, '0, 1'b0, "R9 overflow");
        send(3'd5, mk(0, 5), '0, '0, 1'b0, "R9 count unchanged");
        send(3'd2, mk(0, 5), pat(6), 8'h44, 1'b1, "R5 pointer store heavy");
        send(3'd3, mk(0, 5), '0, '0, 1'b0, "R5 heavy uncommitted");
        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 final drain: actual %0d pending expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule